// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Capture

This block is a register-mapped general-purpose I/O controller for up to 32 pins. Software reaches it through a simple 32-bit register bus with byte addresses on a 4-byte stride. Bit n of every register belongs to pin n. Each pin has four control bits of its own: input enable, output enable, output value and output inversion. The pad itself sits outside the block. The block hands the pad a value and a drive-enable, and the pad tri-states when the enable is low.

Each pin watches for four conditions: a rising edge, a falling edge, a high level and a low level. Every condition has an enable register and a sticky pending register. A pending bit is cleared by writing a one to it. Pin inputs pass through a two-flop synchronizer, and edges are found by comparing the synchronized value with its value one cycle earlier. Each pin drives its own interrupt line, so per-pin lines reach the interrupt controller above without a shared summary line.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every readable register returns zero, `irq` is all zero and `pin_oe` is all zero.
- R2: Input enable (0x04), output enable (0x08), output value (0x0C) and output invert (0x40) return the last value written. The output value register never reflects the pin state.
- R3: `pin_out` equals output value XOR output invert, and `pin_oe` equals the output enable register.
- R4: The input value register (0x00) returns the synchronized pin level ANDed with input enable. A pin change appears there after the second rising clock edge.
- R5: A rising edge on an input-enabled pin sets its bit in rise pending (0x1C), and a falling edge sets its bit in fall pending (0x24). Either bit is set at the third clock edge after the pin changes.
- R6: While an input-enabled pin is high, its bit in high pending (0x2C) is set every cycle. While it is low, its bit in low pending (0x34) is set every cycle.
- R7: Pending bits are sticky. Writing 1 to a pending bit clears it, and bits written as 0 keep their value.
- R8: When a condition sets a pending bit in the same cycle that software writes 1 to clear it, the bit ends set.
- R9: `irq[n]` is high exactly when, for some condition, both the enable bit and the pending bit of pin n are set. The enables for rise, fall, high and low are at 0x18, 0x20, 0x28 and 0x30.
- R10: A pin whose input enable is 0 sets no pending bit and reads 0 at 0x00, whatever it does.
- R11: Reads of unmapped offsets return zero. Writes to 0x00 or to unmapped offsets change nothing. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| pin_in | input | NPINS | Asynchronous pad input levels |
| pin_out | output | NPINS | Value for the pad to drive |
| pin_oe | output | NPINS | Pad drive enable, 1 drives |
| irq | output | NPINS | Per-pin interrupt lines |

## Verification
The collision that matters is a hardware set of a level-pending bit landing in the same cycle as a software write-one-to-clear of that bit. The bench holds an input-enabled pin high so that its high-level condition is true every cycle, then writes a one to that bit of the high pending register. The read that follows must still show the bit set, while the same clear on an edge-pending bit whose condition has passed must leave it at zero. A second collision is a write that clears some bits of a pending register while others are held. Here the bench writes zero to a set rise bit, and the bit must survive.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  irq
);
  localparam int IW = ADDR_W - 2;
  localparam logic [IW-1:0] A_IN    = IW'(6'h00);
  localparam logic [IW-1:0] A_INEN  = IW'(6'h01);
  localparam logic [IW-1:0] A_OE    = IW'(6'h02);
  localparam logic [IW-1:0] A_OV    = IW'(6'h03);
  localparam logic [IW-1:0] A_RIE   = IW'(6'h06);
  localparam logic [IW-1:0] A_RIP   = IW'(6'h07);
  localparam logic [IW-1:0] A_FIE   = IW'(6'h08);
  localparam logic [IW-1:0] A_FIP   = IW'(6'h09);
  localparam logic [IW-1:0] A_HIE   = IW'(6'h0A);
  localparam logic [IW-1:0] A_HIP   = IW'(6'h0B);
  localparam logic [IW-1:0] A_LIE   = IW'(6'h0C);
  localparam logic [IW-1:0] A_LIP   = IW'(6'h0D);
  localparam logic [IW-1:0] A_INV   = IW'(6'h10);

  logic [NPINS-1:0] s1, s2, s3;
  logic [NPINS-1:0] in_en, out_en, out_val, out_inv;
  logic [NPINS-1:0] rise_ie, fall_ie, high_ie, low_ie;
  logic [NPINS-1:0] rise_ip, fall_ip, high_ip, low_ip;
  logic [NPINS-1:0] wd;
  logic [NPINS-1:0] rise_clr, fall_clr, high_clr, low_clr;
  logic [NPINS-1:0] in_val;
  logic [IW-1:0]    idx;
  logic             wr;

  assign idx    = bus_addr[ADDR_W-1:2];
  assign wr     = bus_sel & bus_we;
  assign wd     = bus_wdata[NPINS-1:0];
  assign in_val = s2 & in_en;

  assign rise_clr = (wr && idx == A_RIP) ? wd : '0;
  assign fall_clr = (wr && idx == A_FIP) ? wd : '0;
  assign high_clr = (wr && idx == A_HIP) ? wd : '0;
  assign low_clr  = (wr && idx == A_LIP) ? wd : '0;

  assign pin_out = out_val ^ out_inv;
  assign pin_oe  = out_en;
  assign irq     = (rise_ie & rise_ip) | (fall_ie & fall_ip)
                 | (high_ie & high_ip) | (low_ie & low_ip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_en   <= '0;
      out_en  <= '0;
      out_val <= '0;
      out_inv <= '0;
      rise_ie <= '0;
      fall_ie <= '0;
      high_ie <= '0;
      low_ie  <= '0;
    end else if (wr) begin
      case (idx)
        A_INEN: in_en   <= wd;
        A_OE:   out_en  <= wd;
        A_OV:   out_val <= wd;
        A_INV:  out_inv <= wd;
        A_RIE:  rise_ie <= wd;
        A_FIE:  fall_ie <= wd;
        A_HIE:  high_ie <= wd;
        A_LIE:  low_ie  <= wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_ip <= '0;
      fall_ip <= '0;
      high_ip <= '0;
      low_ip  <= '0;
    end else begin
      rise_ip <= (rise_ip & ~rise_clr) | (s2 & ~s3 & in_en);
      fall_ip <= (fall_ip & ~fall_clr) | (~s2 & s3 & in_en);
      high_ip <= (high_ip & ~high_clr) | (s2 & in_en);
      low_ip  <= (low_ip & ~low_clr) | (~s2 & in_en);
    end
  end

  function automatic logic [31:0] ext(input logic [NPINS-1:0] v);
    logic [31:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (idx)
        A_IN:   bus_rdata = ext(in_val);
        A_INEN: bus_rdata = ext(in_en);
        A_OE:   bus_rdata = ext(out_en);
        A_OV:   bus_rdata = ext(out_val);
        A_RIE:  bus_rdata = ext(rise_ie);
        A_RIP:  bus_rdata = ext(rise_ip);
        A_FIE:  bus_rdata = ext(fall_ie);
        A_FIP:  bus_rdata = ext(fall_ip);
        A_HIE:  bus_rdata = ext(high_ie);
        A_HIP:  bus_rdata = ext(high_ip);
        A_LIE:  bus_rdata = ext(low_ie);
        A_LIP:  bus_rdata = ext(low_ip);
        A_INV:  bus_rdata = ext(out_inv);
        default: bus_rdata = '0;
      endcase
    end
  end

  // R3: the drive enable follows an output-enable write
  p_oe_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == A_OE) |=> (pin_oe == $past(wd)));

  // R5: a qualified rising edge is captured one edge later
  p_rise_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_ip & $past(s2 & ~s3 & in_en)) == $past(s2 & ~s3 & in_en)));

  // R7: bits not written as 1 keep their value
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fall_ip & $past(fall_ip & ~fall_clr)) == $past(fall_ip & ~fall_clr)));

  // R8: a level set beats a same-cycle clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == A_HIP && |(wd & s2 & in_en)) |=> |(high_ip & $past(wd & s2 & in_en)));

  // R9: an interrupt line never rises without a pending source
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~(rise_ip | fall_ip | high_ip | low_ip)) == '0);

  // R10: pins with input disabled never gain a pending bit
  p_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((rise_ip | fall_ip | high_ip | low_ip)
              & ~$past(rise_ip | fall_ip | high_ip | low_ip) & ~$past(in_en)) == '0));

  // R11: writes to the input value offset leave writable state alone
  p_ro_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == A_IN) |=> ($stable(in_en) && $stable(out_en) && $stable(out_val) && $stable(out_inv)));
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  localparam int NPINS = 32;
  localparam int AW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NPINS-1:0] pin_in = '0;
  logic [NPINS-1:0] pin_out, pin_oe, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NPINS), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  // {address, write data, expected read-back}
  localparam int NV = 12;
  localparam logic [71:0] VEC [NV] = '{
    {8'h04, 32'hFFFF00FF, 32'hFFFF00FF},
    {8'h08, 32'hA5A5A5A5, 32'hA5A5A5A5},
    {8'h0C, 32'h12345678, 32'h12345678},
    {8'h40, 32'h0F0F0F0F, 32'h0F0F0F0F},
    {8'h00, 32'hFFFFFFFF, 32'h00000000},
    {8'h10, 32'hFFFFFFFF, 32'h00000000},
    {8'h14, 32'hFFFFFFFF, 32'h00000000},
    {8'h38, 32'hFFFFFFFF, 32'h00000000},
    {8'h3C, 32'hFFFFFFFF, 32'h00000000},
    {8'h44, 32'hFFFFFFFF, 32'h00000000},
    {8'hFC, 32'hFFFFFFFF, 32'h00000000},
    {8'h04, 32'h00000000, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a <= 'h40; a += 4) rd_chk("R1", 8'(a), 32'h0);
    chk("R1 irq", irq, 32'h0);
    chk("R1 oe", pin_oe, 32'h0);

    // R2 / R11 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd_chk((VEC[i][31:0] != 0) ? "R2" : "R11", VEC[i][71:64], VEC[i][31:0]);
    end
    rd_chk("R11 out kept", 8'h0D, 32'h12345678);

    // clear pending left by the walk (R7)
    wr(8'h1C, 32'hFFFFFFFF); wr(8'h24, 32'hFFFFFFFF);
    wr(8'h2C, 32'hFFFFFFFF); wr(8'h34, 32'hFFFFFFFF);
    rd_chk("R7 clear all", 8'h34, 32'h0);

    // R3 pad outputs
    chk("R3 out", pin_out, 32'h12345678 ^ 32'h0F0F0F0F);
    chk("R3 oe", pin_oe, 32'hA5A5A5A5);

    // R10 disabled pin does nothing
    pin_in[7] = 1'b1; repeat (4) @(negedge clk);
    pin_in[7] = 1'b0; repeat (4) @(negedge clk);
    rd_chk("R10 rise", 8'h1C, 32'h0);
    rd_chk("R10 fall", 8'h24, 32'h0);
    pin_in[7] = 1'b1; repeat (3) @(negedge clk);
    rd_chk("R10 in", 8'h00, 32'h0);
    pin_in[7] = 1'b0;

    // R4 synchronizer latency
    wr(8'h04, 32'h00000004);
    pin_in[2] = 1'b1;
    @(negedge clk);
    rd_chk("R4 one edge", 8'h00, 32'h0);
    @(negedge clk);
    rd_chk("R4 two edges", 8'h00, 32'h4);
    repeat (2) @(negedge clk);
    rd_chk("R5 rise", 8'h1C, 32'h4);
    rd_chk("R6 high", 8'h2C, 32'h4);
    rd_chk("R6 low", 8'h34, 32'h4);

    // R7 write-one-to-clear
    wr(8'h1C, 32'h0);
    rd_chk("R7 zero keeps", 8'h1C, 32'h4);
    wr(8'h34, 32'h4);
    rd_chk("R7 low cleared", 8'h34, 32'h0);
    wr(8'h1E, 32'h4);
    rd_chk("R11 low bits ignored, R7 rise cleared", 8'h1C, 32'h0);

    // R8 set beats clear
    wr(8'h2C, 32'h4);
    rd_chk("R8 high", 8'h2C, 32'h4);

    // R9 interrupt lines
    wr(8'h28, 32'h4);
    chk("R9 high irq", irq, 32'h4);
    wr(8'h28, 32'h0);
    chk("R9 off", irq, 32'h0);
    wr(8'h18, 32'h4);
    chk("R9 rise no pend", irq, 32'h0);
    wr(8'h18, 32'h0);

    // R5 falling edge
    pin_in[2] = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R5 fall", 8'h24, 32'h4);
    wr(8'h20, 32'h4);
    chk("R9 fall irq", irq, 32'h4);
    wr(8'h24, 32'h4);
    chk("R9 fall cleared", irq, 32'h0);

    // R6 low level on a high pin number
    wr(8'h04, 32'h80000004);
    wr(8'h30, 32'h80000000);
    repeat (2) @(negedge clk);
    chk("R6 R9 low irq", irq, 32'h80000000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule